// File: doc/BRIEF.md
# SPI Status Flag Controller

This block owns the three status flags of an SPI peripheral that can act as master or slave: transfer complete, write collision and mode fault. The serial shift engine supplies a one-cycle end-of-byte strobe and a transfer-in-progress level. The register bus supplies per-register read and write strobes that are already decoded. The block decides when each flag sets and when it clears, and it presents the flags as a status byte. From the flags it derives an interrupt request and an inhibit that keeps the shift engine from loading a new received byte into the data register.

No flag clears from a single access. Software must first read the status register while the flag is set, which arms that flag. A later access to a second register then clears it: a data-register read or write for transfer complete and write collision, and a control-register-1 write for mode fault. A mode fault happens when slave select is pulled low while the peripheral is master and slave select is configured as a fault input. The block then issues clear pulses that drop the enable bit, the master bit and the three pin-direction bits held in the neighbouring control logic.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, and the interrupt request, the load inhibit and all clear pulses are 0.
- R2: Status byte layout: bit 7 is transfer complete, bit 6 is write collision, bit 4 is mode fault. Bits 5 and 3..0 read 0 even when all three flags are set (value 0xD0).
- R3: A transfer-done strobe sets the transfer-complete flag, which is visible on the status byte one clock later.
- R4: The load inhibit is high exactly while the transfer-complete flag is set.
- R5: Transfer complete clears only on a data-register read or write that comes after a status read which saw the flag set. A data access without that earlier status read leaves the flag set.
- R6: A data-register write while a transfer is in progress sets write collision. A data write with no transfer in progress does not set it. It clears by a status read with the flag set, followed by a data-register access.
- R7: Mode fault sets when master mode, fault-input enable and a low slave select are all present in the same cycle. It does not set if fault-input enable is 0 or if the peripheral is not master.
- R8: In the cycle the mode-fault flag rises, the clear pulses for enable, master and all three pin-direction bits are 1. They return to 0 once the fault condition is gone.
- R9: Mode fault clears only by a status read with the flag set, followed by a control-register-1 write. Data-register accesses leave it set.
- R10: The interrupt request equals interrupt-enable AND (transfer complete OR mode fault). Write collision alone gives no interrupt.
- R11: A write strobe to the status register changes neither the flags nor the arming state.
- R12: If a set event and a completing clear access fall in the same cycle, the flag stays 1 and is disarmed. A further clear access alone then does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_done_i | input | 1 | One-cycle strobe: received byte moved to the data register |
| xfer_busy_i | input | 1 | Transfer in progress |
| ss_n_i | input | 1 | Slave-select pin level, active low |
| master_i | input | 1 | Peripheral is in master mode |
| fault_en_i | input | 1 | Slave select is configured as a mode-fault input |
| irq_en_i | input | 1 | Interrupt enable |
| sts_rd_i | input | 1 | Status register read strobe |
| sts_wr_i | input | 1 | Status register write strobe (ignored) |
| data_rd_i | input | 1 | Data register read strobe |
| data_wr_i | input | 1 | Data register write strobe |
| ctl1_wr_i | input | 1 | Control register 1 write strobe |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |
| load_inhibit_o | output | 1 | Blocks loading of new received data |
| clr_enable_o | output | 1 | Clear pulse for the peripheral-enable bit |
| clr_master_o | output | 1 | Clear pulse for the master-mode bit |
| clr_pindir_o | output | 3 | Clear pulses for the pin-direction bits |

## Verification
The hardest case to reach is the collision between a set event and a completing clear. It needs the flag already set and armed by an earlier status read, and then a transfer-done strobe in the very cycle of the data access. The bench builds this in steps: it sets the flag, reads status, then applies the done strobe and the data read together. It next shows that another data read alone leaves the flag set. A second hard case is a data access arriving before the status read, which must be told apart from a correct clear. The table places data accesses both before and after the arming read.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int STATUS_W  = 8;
  localparam int NUM_FLAGS = 3;
  localparam int POS_XFER  = 7;
  localparam int POS_WCOL  = 6;
  localparam int POS_MODF  = 4;

  typedef enum int unsigned {
    FLG_XFER = 0,
    FLG_WCOL = 1,
    FLG_MODF = 2
  } flag_idx_e;
endpackage

// File: rtl/spi_flag_cell.sv
// One status flag with its own arming bit for the two-step clear.
module spi_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,      // set event this cycle
  input  logic arm_rd_i,   // status read strobe
  input  logic clr_acc_i,  // second-step access strobe
  output logic flag_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic arm_cap, clr_fire;

  always_comb begin
    arm_cap  = arm_rd_i & flag_q;
    clr_fire = armed_q & clr_acc_i;
    flag_d   = flag_q;
    armed_d  = armed_q;
    if (set_i) begin
      flag_d  = 1'b1;
      armed_d = clr_fire ? 1'b0 : (armed_q | arm_cap);
    end else if (clr_fire) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end else begin
      armed_d = flag_q & (armed_q | arm_cap);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q); // R12
  AST_NO_UNARMED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !set_i && !armed_q) |=> flag_q); // R5
  AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> flag_q); // R5
endmodule

// File: rtl/spi_flag_events.sv
// Decodes set events and second-step clear accesses; registers mode-fault clear pulses.
module spi_flag_events
  import spi_flag_pkg::*;
#(
  parameter int NUM_DIR = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfer_done_i,
  input  logic                 xfer_busy_i,
  input  logic                 ss_n_i,
  input  logic                 master_i,
  input  logic                 fault_en_i,
  input  logic                 data_rd_i,
  input  logic                 data_wr_i,
  input  logic                 ctl1_wr_i,
  output logic [NUM_FLAGS-1:0] set_o,
  output logic [NUM_FLAGS-1:0] clr_acc_o,
  output logic                 clr_enable_o,
  output logic                 clr_master_o,
  output logic [NUM_DIR-1:0]   clr_pindir_o
);
  logic fault_hit;
  logic pulse_q, pulse_d;
  logic data_acc;

  always_comb begin
    fault_hit = master_i & fault_en_i & ~ss_n_i;
    data_acc  = data_rd_i | data_wr_i;
    set_o     = '0;
    clr_acc_o = '0;
    set_o[int'(FLG_XFER)]     = xfer_done_i;
    set_o[int'(FLG_WCOL)]     = data_wr_i & xfer_busy_i;
    set_o[int'(FLG_MODF)]     = fault_hit;
    clr_acc_o[int'(FLG_XFER)] = data_acc;
    clr_acc_o[int'(FLG_WCOL)] = data_acc;
    clr_acc_o[int'(FLG_MODF)] = ctl1_wr_i;
    pulse_d   = fault_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign clr_enable_o = pulse_q;
  assign clr_master_o = pulse_q;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    assign clr_pindir_o[g] = pulse_q;
  end

  AST_NO_FAULT_AS_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i || !fault_en_i) |=> !clr_master_o); // R7
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int NUM_DIR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_done_i,
  input  logic               xfer_busy_i,
  input  logic               ss_n_i,
  input  logic               master_i,
  input  logic               fault_en_i,
  input  logic               irq_en_i,
  input  logic               sts_rd_i,
  input  logic               sts_wr_i,
  input  logic               data_rd_i,
  input  logic               data_wr_i,
  input  logic               ctl1_wr_i,
  output logic [STATUS_W-1:0] status_o,
  output logic               irq_o,
  output logic               load_inhibit_o,
  output logic               clr_enable_o,
  output logic               clr_master_o,
  output logic [NUM_DIR-1:0] clr_pindir_o
);
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] flags;

  spi_flag_events #(.NUM_DIR(NUM_DIR)) u_events (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_done_i  (xfer_done_i),
    .xfer_busy_i  (xfer_busy_i),
    .ss_n_i       (ss_n_i),
    .master_i     (master_i),
    .fault_en_i   (fault_en_i),
    .data_rd_i    (data_rd_i),
    .data_wr_i    (data_wr_i),
    .ctl1_wr_i    (ctl1_wr_i),
    .set_o        (set_vec),
    .clr_acc_o    (clr_vec),
    .clr_enable_o (clr_enable_o),
    .clr_master_o (clr_master_o),
    .clr_pindir_o (clr_pindir_o)
  );

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    spi_flag_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_vec[f]),
      .arm_rd_i  (sts_rd_i),
      .clr_acc_i (clr_vec[f]),
      .flag_o    (flags[f])
    );
  end

  always_comb begin
    status_o           = '0;
    status_o[POS_XFER] = flags[int'(FLG_XFER)];
    status_o[POS_WCOL] = flags[int'(FLG_WCOL)];
    status_o[POS_MODF] = flags[int'(FLG_MODF)];
  end

  assign irq_o          = irq_en_i & (flags[int'(FLG_XFER)] | flags[int'(FLG_MODF)]);
  assign load_inhibit_o = flags[int'(FLG_XFER)];

  AST_MODF_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[POS_MODF]) |-> (clr_master_o && clr_enable_o && (&clr_pindir_o))); // R8
  AST_WCOL_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[POS_WCOL] && !status_o[POS_XFER] && !status_o[POS_MODF]) |-> !irq_o); // R10
  AST_STS_WR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr_i && !sts_rd_i && !data_rd_i && !data_wr_i && !ctl1_wr_i
     && !xfer_done_i && !(master_i && fault_en_i && !ss_n_i)) |=> $stable(status_o)); // R11
  AST_INHIBIT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[POS_XFER] |-> load_inhibit_o); // R4
endmodule

// File: tb/tb_spi_flag_ctrl.sv
module tb_spi_flag_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  // stim[9:0] = done,busy,srd,drd,dwr,c1wr,swr,master,fen,ss_n ; then status[7:0], irq
  localparam logic [18:0] VEC [NVEC] = '{
    {10'b1000000001, 8'h80, 1'b1},  // R3 set
    {10'b0001000001, 8'h80, 1'b1},  // R5 data read unarmed
    {10'b0010000001, 8'h80, 1'b1},  // R5 arm
    {10'b0001000001, 8'h00, 1'b0},  // R5 clear
    {10'b0100100001, 8'h40, 1'b0},  // R6 collision, R10 no irq
    {10'b0000100001, 8'h40, 1'b0},  // R6 unarmed write
    {10'b0010000001, 8'h40, 1'b0},  // R6 arm
    {10'b0001000001, 8'h00, 1'b0},  // R6 clear
    {10'b0000100001, 8'h00, 1'b0},  // R6 idle write no set
    {10'b0000000100, 8'h00, 1'b0},  // R7 fault enable off
    {10'b0000000010, 8'h00, 1'b0},  // R7 not master
    {10'b0000000110, 8'h10, 1'b1},  // R7 fault
    {10'b0010000001, 8'h10, 1'b1},  // R9 arm
    {10'b0001100001, 8'h10, 1'b1},  // R9 data access no clear
    {10'b0000010001, 8'h00, 1'b0},  // R9 clear
    {10'b1000000001, 8'h80, 1'b1},  // R11 prep
    {10'b0000001001, 8'h80, 1'b1}   // R11 status write ignored
  };

  logic clk, rst_n;
  logic xfer_done_i, xfer_busy_i, ss_n_i, master_i, fault_en_i, irq_en_i;
  logic sts_rd_i, sts_wr_i, data_rd_i, data_wr_i, ctl1_wr_i;
  logic [7:0] status_o;
  logic irq_o, load_inhibit_o, clr_enable_o, clr_master_o;
  logic [2:0] clr_pindir_o;
  int checks, failures;
  bit finished;

  spi_flag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .xfer_done_i(xfer_done_i), .xfer_busy_i(xfer_busy_i),
    .ss_n_i(ss_n_i), .master_i(master_i), .fault_en_i(fault_en_i), .irq_en_i(irq_en_i),
    .sts_rd_i(sts_rd_i), .sts_wr_i(sts_wr_i), .data_rd_i(data_rd_i), .data_wr_i(data_wr_i),
    .ctl1_wr_i(ctl1_wr_i), .status_o(status_o), .irq_o(irq_o),
    .load_inhibit_o(load_inhibit_o), .clr_enable_o(clr_enable_o),
    .clr_master_o(clr_master_o), .clr_pindir_o(clr_pindir_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] s);
    {xfer_done_i, xfer_busy_i, sts_rd_i, data_rd_i, data_wr_i,
     ctl1_wr_i, sts_wr_i, master_i, fault_en_i, ss_n_i} = s;
    @(negedge clk);
    {xfer_done_i, xfer_busy_i, sts_rd_i, data_rd_i, data_wr_i,
     ctl1_wr_i, sts_wr_i, master_i, fault_en_i, ss_n_i} = 10'b0000000001;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; finished = 0;
    rst_n = 1'b0; irq_en_i = 1'b1;
    {xfer_done_i, xfer_busy_i, sts_rd_i, data_rd_i, data_wr_i,
     ctl1_wr_i, sts_wr_i, master_i, fault_en_i, ss_n_i} = 10'b0000000001;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(status_o == 8'h00, "R1 status", status_o, 0);
    check({irq_o, load_inhibit_o, clr_enable_o, clr_master_o, clr_pindir_o} == 7'b0,
          "R1 outputs", {irq_o, load_inhibit_o, clr_enable_o, clr_master_o, clr_pindir_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][18:9]);
      check(status_o == VEC[i][8:1], $sformatf("vec%0d status", i), status_o, VEC[i][8:1]);
      check(irq_o == VEC[i][0], $sformatf("vec%0d irq R10", i), irq_o, VEC[i][0]);
      check(load_inhibit_o == status_o[7], $sformatf("vec%0d R4 inhibit", i),
            load_inhibit_o, status_o[7]);
    end

    // clear transfer-complete left set by the table
    drive(10'b0010000001); drive(10'b0001000001);
    check(status_o == 8'h00, "R5 cleanup", status_o, 0);

    // R12: set and completing clear in the same cycle
    drive(10'b1000000001);
    drive(10'b0010000001);
    drive(10'b1001000001);
    check(status_o[7] == 1'b1, "R12 set wins", status_o[7], 1);
    drive(10'b0001000001);
    check(status_o[7] == 1'b1, "R12 disarmed", status_o[7], 1);
    drive(10'b0010000001); drive(10'b0001000001);
    check(status_o[7] == 1'b0, "R12 rearm clear", status_o[7], 0);

    // R8 mode-fault clear pulses
    drive(10'b0000000110);
    check({clr_enable_o, clr_master_o, clr_pindir_o} == 5'b11111, "R8 pulses",
          {clr_enable_o, clr_master_o, clr_pindir_o}, 5'b11111);
    check(status_o[4] == 1'b1, "R8 flag", status_o[4], 1);
    @(negedge clk);
    check({clr_enable_o, clr_master_o, clr_pindir_o} == 5'b0, "R8 pulses end",
          {clr_enable_o, clr_master_o, clr_pindir_o}, 0);

    // R2 all flags set, reserved bits zero
    drive(10'b1100100001);
    check(status_o == 8'hD0, "R2 layout", status_o, 8'hD0);

    // R10 interrupt enable off
    irq_en_i = 1'b0;
    @(negedge clk);
    check(irq_o == 1'b0, "R10 irq disabled", irq_o, 0);
    irq_en_i = 1'b1;

    // R11 status write with armed flags: still set afterwards
    drive(10'b0010000001);
    drive(10'b0000001001);
    check(status_o == 8'hD0, "R11 write ignored", status_o, 8'hD0);

    // R1 reset again clears all
    rst_n = 1'b0;
    @(negedge clk);
    check(status_o == 8'h00, "R1 reset clears", status_o, 0);
    rst_n = 1'b1;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule